// File: doc/BRIEF.md
# Universal Shift Register with Shared Bus

This block is a W-bit storage register (eight stages by default, named A at bit 0 through H at bit W-1) that on each rising clock edge either keeps its contents, shifts toward the high stage, shifts toward the low stage, or loads a parallel word. A two-bit select picks the operation. An active-low synchronous clear overrides all four operations.

The parallel pins are shared. One bus both supplies load data and carries the register contents out through tri-state drivers. The bus is modelled as three signals: an input for the data another agent drives, an output for the data this block drives, and a drive-enable flag. When the drive-enable flag is low, the bus is at high impedance. The drivers turn on only when both active-low output enables are asserted and the select is not asking for a load. This lets an external agent drive load data whatever the output enables are doing.

Two serial outputs always show stage A and stage H, and two serial inputs feed the vacated end stage during shifts. Units can therefore be chained into longer words. To chain them, connect one unit's high-end output to the next unit's right serial input, and that unit's low-end output back to the first unit's left serial input.

Top module: `usr_bus_reg`

## Requirements
- R1: When `clr_n` is sampled low at a rising edge, every stage becomes 0 after that edge, whatever `sel` is.
- R2: With `clr_n` high and `sel` = 2'b00 (hold), the contents do not change at the edge.
- R3: With `sel` = 2'b01 (shift right), stage A takes `ser_r_in` and stage i takes the old value of stage i-1.
- R4: With `sel` = 2'b10 (shift left), stage H takes `ser_l_in` and stage i takes the old value of stage i+1.
- R5: With `sel` = 2'b11 (load), the register takes `bus_in` at the edge, with bit 0 going to stage A.
- R6: `bus_drv` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0 and `sel` is not 2'b11. The flag follows its inputs without waiting for a clock.
- R7: `bus_out` equals the register contents while `bus_drv` is 1, and is all zeros while the bus is released.
- R8: `tail_first` always shows stage A and `tail_last` always shows stage H, whatever the state of the bus drivers.
- R9: A low pulse on `clr_n` that begins and ends between rising edges does not change the contents.
- R10: Two units chained through their serial pins behave as one register of twice the width when shifted in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clr_n | input | 1 | Synchronous clear, active low |
| sel | input | 2 | Operation: 00 hold, 01 shift right, 10 shift left, 11 load |
| oe_a_n | input | 1 | First bus output enable, active low |
| oe_b_n | input | 1 | Second bus output enable, active low |
| ser_r_in | input | 1 | Serial input entering stage A during shift right |
| ser_l_in | input | 1 | Serial input entering stage H during shift left |
| bus_in | input | W | Data driven onto the shared bus by another agent |
| bus_out | output | W | Data this block drives onto the shared bus |
| bus_drv | output | 1 | 1 when this block drives the bus; 0 means high impedance |
| tail_first | output | 1 | Serial output from stage A |
| tail_last | output | 1 | Serial output from stage H |

## Verification
A 16-bit model of two chained units is driven with random selects, serial bits, enables and bus words, while clear is held mostly inactive. Because both shift directions travel across the unit boundary, an error in stage ordering, in shift direction or in the chaining connections shows up as a mismatch at the serial outputs. The drive-enable flag is compared against all combinations of the two enables and the four selects, which tells an OR of the enables apart from an AND, and shows whether load mode releases the bus. Directed cases then load a known pattern and apply a clear during a load. They also pulse clear between edges, which separates a synchronous clear from an asynchronous one.

// File: rtl/usr_pkg.sv
package usr_pkg;
    typedef enum logic [2:0] {
        OP_CLEAR = 3'd0,
        OP_HOLD  = 3'd1,
        OP_SHR   = 3'd2,
        OP_SHL   = 3'd3,
        OP_LOAD  = 3'd4
    } op_e;
endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic       clr_n,
    input  logic [1:0] sel,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output op_e        op,
    output logic       drv
);
    always_comb begin
        op = OP_HOLD;
        if (!clr_n) begin
            op = OP_CLEAR;
        end else begin
            unique case (sel)
                2'b00:   op = OP_HOLD;
                2'b01:   op = OP_SHR;
                2'b10:   op = OP_SHL;
                default: op = OP_LOAD;
            endcase
        end
    end

    // bus released during load regardless of enables
    assign drv = !oe_a_n && !oe_b_n && (sel != 2'b11);

    // R6: a load select always releases the bus
    always_comb begin
        a_r6_load_releases: assert (!(sel == 2'b11 && drv));
    end
endmodule

// File: rtl/usr_stage_array.sv
module usr_stage_array
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  op_e          op,
    input  logic         ser_r,
    input  logic         ser_l,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);
    localparam int LAST = W - 1;

    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic from_lo;
        logic from_hi;
        if (i == 0) begin : g_lo_end
            assign from_lo = ser_r;
        end else begin : g_lo_mid
            assign from_lo = q[i-1];
        end
        if (i == LAST) begin : g_hi_end
            assign from_hi = ser_l;
        end else begin : g_hi_mid
            assign from_hi = q[i+1];
        end
        always_comb begin
            unique case (op)
                OP_CLEAR: nxt[i] = 1'b0;
                OP_HOLD:  nxt[i] = q[i];
                OP_SHR:   nxt[i] = from_lo;
                OP_SHL:   nxt[i] = from_hi;
                OP_LOAD:  nxt[i] = par_in[i];
                default:  nxt[i] = q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        q <= nxt;
    end

    // checker bookkeeping: contents are defined once a clear has been taken
    logic known_q = 1'b0;
    always_ff @(posedge clk) begin
        if (op == OP_CLEAR) known_q <= 1'b1;
    end

    a_r1_clear_zeroes: assert property (@(posedge clk)
        (op == OP_CLEAR) |=> (q == '0));
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!known_q)
        (op == OP_HOLD) |=> $stable(q));
    a_r3_shift_right: assert property (@(posedge clk) disable iff (!known_q)
        (op == OP_SHR) |=> (q == {$past(q[LAST-1:0]), $past(ser_r)}));
    a_r4_shift_left: assert property (@(posedge clk) disable iff (!known_q)
        (op == OP_SHL) |=> (q == {$past(ser_l), $past(q[LAST:1])}));
    a_r5_load: assert property (@(posedge clk)
        (op == OP_LOAD) |=> (q == $past(par_in)));
endmodule

// File: rtl/usr_bus_reg.sv
module usr_bus_reg
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [1:0]   sel,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic         ser_r_in,
    input  logic         ser_l_in,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_out,
    output logic         bus_drv,
    output logic         tail_first,
    output logic         tail_last
);
    op_e          op;
    logic [W-1:0] q;

    usr_mode_decode u_dec (
        .clr_n  (clr_n),
        .sel    (sel),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .op     (op),
        .drv    (bus_drv)
    );

    usr_stage_array #(.W(W)) u_stages (
        .clk    (clk),
        .op     (op),
        .ser_r  (ser_r_in),
        .ser_l  (ser_l_in),
        .par_in (bus_in),
        .q      (q)
    );

    assign bus_out    = bus_drv ? q : '0;
    assign tail_first = q[0];
    assign tail_last  = q[W-1];

    // R7: released bus never carries data
    always_comb begin
        a_r7_released_zero: assert (bus_drv || (bus_out == '0));
    end
endmodule

// File: tb/usr_bus_reg_test.sv
module usr_bus_reg_test;
    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         clr_n = 1'b0;
    logic [1:0]   sel = 2'b00;
    logic         oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic         ser_r = 1'b0, ser_l = 1'b0;
    logic [W-1:0] bin_lo = '0, bin_hi = '0;
    logic [W-1:0] bout_lo, bout_hi;
    logic         drv_lo, drv_hi;
    logic         lo_first, lo_last, hi_first, hi_last;

    usr_bus_reg #(.W(W)) uut (
        .clk(clk), .clr_n(clr_n), .sel(sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_r_in(ser_r), .ser_l_in(hi_first), .bus_in(bin_lo),
        .bus_out(bout_lo), .bus_drv(drv_lo), .tail_first(lo_first), .tail_last(lo_last)
    );
    usr_bus_reg #(.W(W)) uut_hi (
        .clk(clk), .clr_n(clr_n), .sel(sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_r_in(lo_last), .ser_l_in(ser_l), .bus_in(bin_hi),
        .bus_out(bout_hi), .bus_drv(drv_hi), .tail_first(hi_first), .tail_last(hi_last)
    );

    int n_chk = 0, n_bad = 0;
    logic [2*W-1:0] exp = '0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] want);
        n_chk++;
        if (act !== want) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, want);
        end
    endtask

    function automatic logic [2*W-1:0] model_next(input logic [2*W-1:0] cur,
            input logic c_n, input logic [1:0] s, input logic sr, input logic sl,
            input logic [W-1:0] lo, input logic [W-1:0] hi);
        if (!c_n) return '0;
        case (s)
            2'b00:   return cur;
            2'b01:   return {cur[2*W-2:0], sr};
            2'b10:   return {sl, cur[2*W-1:1]};
            default: return {hi, lo};
        endcase
    endfunction

    function automatic logic drv_model(input logic a, input logic b, input logic [1:0] s);
        return !a && !b && s != 2'b11;
    endfunction

    task automatic check_state(input string req);
        chk({req, "/R8 lo first"}, 16'(lo_first), 16'(exp[0]));
        chk({req, "/R8 lo last"},  16'(lo_last),  16'(exp[W-1]));
        chk({req, "/R10 hi first"}, 16'(hi_first), 16'(exp[W]));
        chk({req, "/R8 hi last"},  16'(hi_last),  16'(exp[2*W-1]));
    endtask

    task automatic step(input logic c_n, input logic [1:0] s, input logic a, input logic b,
                        input logic sr, input logic sl, input logic [W-1:0] lo,
                        input logic [W-1:0] hi, input string req);
        logic d;
        @(negedge clk);
        check_state(req);
        d = drv_model(a, b, s);
        clr_n = c_n; sel = s; oe_a_n = a; oe_b_n = b; ser_r = sr; ser_l = sl;
        bin_lo = d ? '0 : lo;   // bus driven externally only while released
        bin_hi = d ? '0 : hi;
        #1;
        chk("R6 drive flag", 16'(drv_lo), 16'(d));
        chk("R7 bus lo", 16'(bout_lo), d ? 16'(exp[W-1:0]) : 16'h0);
        chk("R7 bus hi", 16'(bout_hi), d ? 16'(exp[2*W-1:W]) : 16'h0);
        @(posedge clk);
        exp = model_next(exp, c_n, s, sr, sl, bin_lo, bin_hi);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: clear from unknown state, during a load select
        step(1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, "R1");
        // R5: load known pattern, then read it back with drivers on (R2 hold)
        step(1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, "R5");
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R2");
        step(1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R2");
        // R9: clear pulse between edges has no effect
        @(negedge clk);
        clr_n = 1'b0; #1; clr_n = 1'b1;
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R9");
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R9");
        chk("R9 contents kept", {bout_hi, bout_lo}, 16'h3CA5);
        // R3, R4 and R10: directed shifts across the unit boundary
        for (int k = 0; k < 9; k++)
            step(1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R3");
        for (int k = 0; k < 9; k++)
            step(1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R4");
        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(r != 4'd0, 2'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0),
                 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), "R10 mix");
        end
        // R1: clear wins over a shift
        step(1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, "R1");
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R1");
        @(negedge clk); #1;
        chk("R1 cleared", {bout_hi, bout_lo}, 16'h0000);
        check_state("R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule